// File: doc/BRIEF.md
# SPI Chip-Select Controller

This block drives the chip-select pins of an SPI host. Software configures it through a small register port: one register picks which line is the current target, one gives each line its idle (deasserted) level, and one selects how the target line follows the serial engine's frames. The serial engine reports a frame in progress on `frame_active`. The block turns that indication and the three registers into one registered level per chip-select pin.

Every write is checked against the number of lines that are built. A value out of range is dropped, and the register keeps its previous contents. The idle-level register comes out of reset with every built line idling high. A line is asserted by driving the inverse of its idle level. Four control modes are available:
- Automatic: the line is asserted only while a frame runs.
- Alternate automatic: behaves the same as automatic.
- Hold: once a frame has started, the line stays asserted between frames until software rewrites the target or the mode.
- Off: the line never asserts.

Top module: `spi_cs_ctrl`

## Requirements
- R1: After reset every `cs_n` pin is 1, the target register reads 0, the idle-level register reads all ones for the NUM_CS built lines (0xF when NUM_CS is 4), and the mode register reads 0.
- R2: A write to the target register (byte address 0x10) with a value below NUM_CS is stored. A later read returns it.
- R3: A write to the target register with a value of NUM_CS or more, compared over all 32 bits, leaves the register unchanged.
- R4: A write to the idle-level register (address 0x14) is stored when the value is below 2^NUM_CS. Otherwise it leaves the register unchanged.
- R5: A write to the mode register (address 0x18) stores values 0 to 3. Any larger value leaves the register unchanged.
- R6: In mode 0 or 1, the target line drives the inverse of its idle bit in the cycle after each clock edge at which `frame_active` is 1. After any other edge it drives its idle bit.
- R7: A line other than the target always drives its idle bit. At most one line differs from its idle level at any time.
- R8: In mode 2, an edge with `frame_active` high latches the target line asserted. The line stays asserted with `frame_active` low until an accepted write to the target or mode register. That write releases the latch even when it stores the same value.
- R9: In mode 3, every line drives its idle bit whatever `frame_active` does.
- R10: A read request (`reg_req` high, `reg_we` low) raises `reg_rvalid` for exactly the next cycle. `reg_rdata` then holds the addressed register, zero-extended. Any other address reads as 0.
- R11: Register and pin changes take effect at the clock edge that accepts the write. The pins reflect the new state one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_req | input | 1 | Register access request for this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid while reg_rvalid is high |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read request |
| frame_active | input | 1 | Serial engine is inside a frame |
| cs_n | output | NUM_CS | Chip-select pin levels |

## Verification
The hardest state to reach is a hold-mode line that has latched and then sees `frame_active` fall. The latch must survive idle cycles, reads and rejected writes, and only an accepted target or mode write may release it. The directed part enters mode 2, pulses one frame, and then issues a read and an out-of-range mode write while checking the pin. After that it releases the latch with a same-value mode write. The random part mixes frame pulses with writes whose values straddle each range limit, so latch releases and rejected writes keep interleaving.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  // Byte offsets of the three registers.
  localparam int OFS_TARGET = 16;
  localparam int OFS_IDLE   = 20;
  localparam int OFS_MODE   = 24;

  typedef enum logic [1:0] {
    CSM_AUTO     = 2'd0,
    CSM_AUTO_ALT = 2'd1,
    CSM_HOLD     = 2'd2,
    CSM_OFF      = 2'd3
  } cs_mode_e;
endpackage

// File: rtl/spi_cs_regs.sv
module spi_cs_regs
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 1,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEL_W-1:0]  sel_q,
  output logic [NUM_CS-1:0] idle_q,
  output cs_mode_e          mode_q,
  output logic              release_hold,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  localparam logic [NUM_CS-1:0] IDLE_RST = '1;

  logic hit_sel, hit_idle, hit_mode;
  logic sel_ok, idle_ok, mode_ok;
  logic acc_sel, acc_idle, acc_mode;
  logic [DATA_W-1:0] rd_mux;

  assign hit_sel  = (addr == ADDR_W'(OFS_TARGET));
  assign hit_idle = (addr == ADDR_W'(OFS_IDLE));
  assign hit_mode = (addr == ADDR_W'(OFS_MODE));

  // Range checks over the full write word
  assign sel_ok  = (wdata < DATA_W'(NUM_CS));
  assign idle_ok = ((wdata >> NUM_CS) == '0);
  assign mode_ok = (wdata < DATA_W'(4));

  assign acc_sel  = req & we & hit_sel  & sel_ok;
  assign acc_idle = req & we & hit_idle & idle_ok;
  assign acc_mode = req & we & hit_mode & mode_ok;

  assign release_hold = acc_sel | acc_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      idle_q <= IDLE_RST;
      mode_q <= CSM_AUTO;
    end else begin
      if (acc_sel)  sel_q  <= wdata[SEL_W-1:0];
      if (acc_idle) idle_q <= wdata[NUM_CS-1:0];
      if (acc_mode) mode_q <= cs_mode_e'(wdata[1:0]);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_sel)       rd_mux = DATA_W'(sel_q);
    else if (hit_idle) rd_mux = DATA_W'(idle_q);
    else if (hit_mode) rd_mux = DATA_W'(mode_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= req & ~we;
      if (req && !we) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/spi_cs_hold.sv
module spi_cs_hold
  import spi_cs_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cs_mode_e mode,
  input  logic     frame_active,
  input  logic     release_hold,
  output logic     held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   held <= 1'b0;
    else if (release_hold)                        held <= 1'b0;
    else if (mode == CSM_HOLD && frame_active)    held <= 1'b1;
  end
endmodule

// File: rtl/spi_cs_drive.sv
module spi_cs_drive
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 1,
  parameter int SEL_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  sel,
  input  logic [NUM_CS-1:0] idle,
  input  cs_mode_e          mode,
  input  logic              held,
  input  logic              frame_active,
  output logic [NUM_CS-1:0] cs_n
);
  logic engage;
  logic [NUM_CS-1:0] cs_d;

  assign engage = (mode != CSM_OFF) &
                  (frame_active | (held & (mode == CSM_HOLD)));

  for (genvar i = 0; i < NUM_CS; i++) begin : g_line
    logic on;
    assign on      = engage & (sel == SEL_W'(i));
    assign cs_d[i] = idle[i] ^ on;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_n <= '1;
    else        cs_n <= cs_d;
  end
endmodule

// File: rtl/spi_cs_ctrl.sv
module spi_cs_ctrl
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 1,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_req,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              reg_rvalid,
  input  logic              frame_active,
  output logic [NUM_CS-1:0] cs_n
);
  localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic [SEL_W-1:0]  sel_q;
  logic [NUM_CS-1:0] idle_q;
  cs_mode_e          mode_q;
  logic              release_hold;
  logic              held;

  spi_cs_regs #(
    .NUM_CS(NUM_CS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .req(reg_req), .we(reg_we),
    .addr(reg_addr), .wdata(reg_wdata),
    .sel_q(sel_q), .idle_q(idle_q), .mode_q(mode_q),
    .release_hold(release_hold), .rdata(reg_rdata), .rvalid(reg_rvalid)
  );

  spi_cs_hold u_hold (
    .clk(clk), .rst_n(rst_n), .mode(mode_q), .frame_active(frame_active),
    .release_hold(release_hold), .held(held)
  );

  spi_cs_drive #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_drive (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .idle(idle_q), .mode(mode_q),
    .held(held), .frame_active(frame_active), .cs_n(cs_n)
  );
endmodule

// File: rtl/spi_cs_chk.sv
module spi_cs_chk
  import spi_cs_pkg::*;
#(
  parameter int NUM_CS = 1,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8,
  parameter int SEL_W  = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_req,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              reg_rvalid,
  input logic              frame_active,
  input logic [NUM_CS-1:0] cs_n,
  input logic [SEL_W-1:0]  sel_q,
  input logic [NUM_CS-1:0] idle_q,
  input logic [1:0]        mode_q
);
  AST_SEL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == ADDR_W'(OFS_TARGET) && reg_wdata >= DATA_W'(NUM_CS))
    |=> $stable(sel_q)); // R3

  AST_IDLE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == ADDR_W'(OFS_IDLE) && (reg_wdata >> NUM_CS) != '0)
    |=> $stable(idle_q)); // R4

  AST_MODE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == ADDR_W'(OFS_MODE) && reg_wdata > DATA_W'(3))
    |=> $stable(mode_q)); // R5

  AST_AUTO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) != 2'd2 && !$past(frame_active)) |-> (cs_n == $past(idle_q))); // R6

  AST_SINGLE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> ($countones(cs_n ^ $past(idle_q)) <= 1)); // R7

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == 2'd3) |-> (cs_n == $past(idle_q))); // R9

  AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && !reg_we) |=> reg_rvalid); // R10
endmodule

bind spi_cs_ctrl spi_cs_chk #(
  .NUM_CS(NUM_CS), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid),
  .frame_active(frame_active), .cs_n(cs_n), .sel_q(sel_q),
  .idle_q(idle_q), .mode_q(mode_q)
);

// File: tb/tb_spi_cs_ctrl.sv
`timescale 1ns/1ps
module tb_spi_cs_ctrl;
  localparam int N = 4;
  localparam logic [7:0] A_SEL = 8'h10, A_IDLE = 8'h14, A_MODE = 8'h18, A_NONE = 8'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_req = 1'b0, reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic        frame_active = 1'b0;
  logic [N-1:0] cs_n;

  int checks = 0, errors = 0;

  // model state
  logic [1:0]   m_sel = '0;
  logic [N-1:0] m_idle = '1;
  logic [1:0]   m_mode = '0;
  logic         m_held = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  spi_cs_ctrl #(.NUM_CS(N)) dut (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .frame_active(frame_active), .cs_n(cs_n)
  );

  function automatic logic [N-1:0] exp_pins(logic [1:0] sel, logic [N-1:0] idle,
                                            logic [1:0] mode, logic held, logic frame);
    logic [N-1:0] r = idle;
    logic act = (mode != 2'd3) && (frame || (held && mode == 2'd2));
    if (act) r[sel] = ~idle[sel];
    return r;
  endfunction

  function automatic logic [31:0] exp_read(logic [7:0] a);
    if (a == A_SEL)  return 32'(m_sel);
    if (a == A_IDLE) return 32'(m_idle);
    if (a == A_MODE) return 32'(m_mode);
    return 32'd0;
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string mode_tag(logic [1:0] m);
    if (m == 2'd3) return "R9";
    if (m == 2'd2) return "R8";
    return "R6";
  endfunction

  // One cycle: drive at negedge, update model, check after the edge.
  task automatic step(input logic req, input logic we, input logic [7:0] a,
                      input logic [31:0] d, input logic frame, input string tag);
    logic [N-1:0] e_cs;
    logic [31:0]  e_rd;
    logic acc_s, acc_i, acc_m, is_rd;
    reg_req = req; reg_we = we; reg_addr = a; reg_wdata = d; frame_active = frame;
    e_cs  = exp_pins(m_sel, m_idle, m_mode, m_held, frame);
    e_rd  = exp_read(a);
    is_rd = req && !we;
    acc_s = req && we && a == A_SEL  && d < 32'(N);
    acc_i = req && we && a == A_IDLE && d < (32'd1 << N);
    acc_m = req && we && a == A_MODE && d <= 32'd3;
    if (acc_s || acc_m) m_held = 1'b0;
    else if (m_mode == 2'd2 && frame) m_held = 1'b1;
    if (acc_s) m_sel = d[1:0];
    if (acc_i) m_idle = d[N-1:0];
    if (acc_m) m_mode = d[1:0];
    @(posedge clk);
    @(negedge clk);
    chk(cs_n == e_cs, (tag == "") ? mode_tag(m_mode) : tag, 32'(cs_n), 32'(e_cs)); // R11 timing
    chk(reg_rvalid == is_rd, "R10", 32'(reg_rvalid), 32'(is_rd));
    if (is_rd) chk(reg_rdata == e_rd, "R10", reg_rdata, e_rd);
    reg_req = 1'b0; reg_we = 1'b0; frame_active = 1'b0;
  endtask

  task automatic rd_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    step(1'b1, 1'b0, a, 32'd0, 1'b0, "");
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1'b1, 1'b1, a, d, 1'b0, "");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(cs_n == 4'hF, "R1", 32'(cs_n), 32'hF);
    rst_n = 1'b1;
    @(negedge clk);
    rd_check(A_SEL, 32'd0, "R1");
    rd_check(A_IDLE, 32'hF, "R1");
    rd_check(A_MODE, 32'd0, "R1");

    // target register range
    wr(A_SEL, 32'd2);
    rd_check(A_SEL, 32'd2, "R2");
    wr(A_SEL, 32'd4);
    rd_check(A_SEL, 32'd2, "R3");
    wr(A_SEL, 32'hFFFF_FFF1);
    rd_check(A_SEL, 32'd2, "R3");

    // idle-level range
    wr(A_IDLE, 32'h5);
    rd_check(A_IDLE, 32'h5, "R4");
    wr(A_IDLE, 32'h10);
    rd_check(A_IDLE, 32'h5, "R4");

    // mode range
    wr(A_MODE, 32'd7);
    rd_check(A_MODE, 32'd0, "R5");

    // auto: frame pulse on line 2 of idle 0101
    step(1'b0, 1'b0, 8'h0, 32'd0, 1'b1, "R6");
    chk(cs_n == 4'h1, "R6", 32'(cs_n), 32'h1);
    step(1'b0, 1'b0, 8'h0, 32'd0, 1'b0, "R6");
    chk(cs_n == 4'h5, "R6", 32'(cs_n), 32'h5);

    // target line 1, others keep idle
    wr(A_SEL, 32'd1);
    step(1'b0, 1'b0, 8'h0, 32'd0, 1'b1, "R7");
    chk(cs_n == 4'h7, "R7", 32'(cs_n), 32'h7);

    // hold mode persistence
    wr(A_MODE, 32'd2);
    step(1'b0, 1'b0, 8'h0, 32'd0, 1'b1, "R8");
    step(1'b0, 1'b0, 8'h0, 32'd0, 1'b0, "R8");
    chk(cs_n == 4'h7, "R8", 32'(cs_n), 32'h7);
    rd_check(A_NONE, 32'd0, "R10");
    wr(A_MODE, 32'd9);
    step(1'b0, 1'b0, 8'h0, 32'd0, 1'b0, "R8");
    chk(cs_n == 4'h7, "R8", 32'(cs_n), 32'h7);
    wr(A_MODE, 32'd2); // same value releases
    step(1'b0, 1'b0, 8'h0, 32'd0, 1'b0, "R8");
    chk(cs_n == 4'h5, "R8", 32'(cs_n), 32'h5);

    // off mode
    wr(A_MODE, 32'd3);
    step(1'b0, 1'b0, 8'h0, 32'd0, 1'b1, "R9");
    step(1'b0, 1'b0, 8'h0, 32'd0, 1'b1, "R9");
    chk(cs_n == 4'h5, "R9", 32'(cs_n), 32'h5);

    // mode 1 behaves as auto
    wr(A_MODE, 32'd1);
    step(1'b0, 1'b0, 8'h0, 32'd0, 1'b1, "R6");
    chk(cs_n == 4'h7, "R6", 32'(cs_n), 32'h7);

    // random mix
    for (int k = 0; k < 4000; k++) begin
      int unsigned op = $urandom_range(0, 9);
      logic fr = ($urandom_range(0, 3) == 0);
      logic [31:0] v = ($urandom_range(0, 15) == 0) ? $urandom() : 32'($urandom_range(0, 20));
      case (op)
        0, 1: step(1'b1, 1'b1, A_SEL, v, fr, "");
        2:    step(1'b1, 1'b1, A_IDLE, v, fr, "");
        3:    step(1'b1, 1'b1, A_MODE, 32'(v % 6), fr, "");
        4, 5: begin
          logic [7:0] ra;
          case ($urandom_range(0, 3))
            0: ra = A_SEL;
            1: ra = A_IDLE;
            2: ra = A_MODE;
            default: ra = A_NONE;
          endcase
          step(1'b1, 1'b0, ra, 32'd0, fr, "");
        end
        default: step(1'b0, 1'b0, 8'h0, 32'd0, fr, "");
      endcase
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule